// File: doc/BRIEF.md
# MAC Merge Verify Handshake Controller

This block runs the link-partner check that must succeed before a transmitter may preempt express traffic with fragments of normal frames. Once receive-side preemption, transmit-side preemption and verification are all enabled and the link is up, it starts on a start pulse or on every rising edge of the link. It asks the frame builder to emit Verify frames at a programmable interval and watches for the partner's Response. It reports progress as a small status code. When the partner answers in time, the transmit-preemption enable rises on the following timer expiry. If the partner stays silent after a bounded number of Verify requests, the status becomes failed.

In parallel, and independently of its own progress, the block answers every Verify that the partner sends by requesting a Response frame, as long as receive-side preemption is active. Frame encoding is done elsewhere: the block only issues one-cycle request pulses and takes one-cycle event pulses back. The interval is given in milliseconds, and a cycle prescaler that is fixed at build time turns milliseconds into clock cycles. When verification is switched off, the transmit enable follows the configuration directly and no handshake runs.

Top module: `mm_verify_fsm`

## Requirements
- R1: Synchronous active-low reset gives status DISABLED (code 0), and `tx_preempt_en`, `rx_preempt_en`, `send_verify` and `send_resp` all low.
- R2: The status codes are DISABLED=0, INITIAL=1, VERIFYING=2, SUCCEEDED=3 and FAILED=4. A `start` pulse sampled while `cfg_verify_en`, `cfg_tx_en`, `cfg_rx_en` and `link_ok` are all high sets the status to INITIAL, reloads the retry budget and clears `tx_preempt_en` one cycle later.
- R3: The first timer expiry follows the start at once, so `send_verify` is high during the second cycle after the start is sampled. Each later `send_verify` follows the previous one after `max(cfg_interval_ms,1)*CYC_PER_MS + 1` cycles.
- R4: At most MAX_VERIFY (default 3) `send_verify` pulses go out per handshake. The expiry that finds no budget left in INITIAL or VERIFYING sets FAILED and stops the timer.
- R5: A `ev_verify_sent` pulse moves INITIAL to VERIFYING and has no effect in any other state.
- R6: A `ev_resp_rcvd` pulse moves VERIFYING to SUCCEEDED and rearms the timer for one interval. In any other state it has no effect.
- R7: In SUCCEEDED, the next timer expiry sets `tx_preempt_en`, one interval plus one cycle after the response is sampled, and then stops the timer.
- R8: A `ev_verify_rcvd` pulse produces a `send_resp` pulse in the next cycle whenever `cfg_rx_en` and `link_ok` are high, whatever the status.
- R9: A rising edge of `link_ok` with all three enables high restarts the handshake from INITIAL. While `link_ok` is low, `tx_preempt_en` and `rx_preempt_en` are low one cycle later and the timer is stopped.
- R10: While `cfg_verify_en` is low, the status is DISABLED, no requests are issued and `tx_preempt_en` follows `cfg_tx_en & link_ok` with one cycle of delay.
- R11: When `cfg_rx_en` or `link_ok` is low, the three event inputs have no effect on status or on `send_resp`. `rx_preempt_en` is `cfg_rx_en & link_ok` delayed by one cycle.
- R12: FAILED and SUCCEEDED are left only by a restart (start pulse or link-up), by disabling verification, or (SUCCEEDED) not at all by events.
- R13: Within one cycle the timer expiry is applied first and the events act on its result. Disabling verification, link-down, start and link-up each override both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_rx_en | input | 1 | Receive-side preemption enabled |
| cfg_tx_en | input | 1 | Transmit-side preemption requested |
| cfg_verify_en | input | 1 | Run the verify handshake before enabling transmit preemption |
| cfg_interval_ms | input | MS_W | Verify interval in milliseconds (0 treated as 1) |
| start | input | 1 | Pulse: (re)start the handshake |
| link_ok | input | 1 | Link up level |
| ev_verify_sent | input | 1 | Pulse: local Verify frame left the port |
| ev_verify_rcvd | input | 1 | Pulse: partner Verify frame received |
| ev_resp_rcvd | input | 1 | Pulse: partner Response frame received |
| status | output | 3 | Handshake status code |
| tx_preempt_en | output | 1 | Transmit preemption enable |
| rx_preempt_en | output | 1 | Receive preemption active |
| send_verify | output | 1 | Pulse: request one Verify frame |
| send_resp | output | 1 | Pulse: request one Response frame |

## Verification
The assertions assume that the three event inputs are single-cycle pulses, that `link_ok` and the configuration inputs are synchronous to `clk`, and that nothing other than this block decides when Verify frames go out. The stimulus drives every input just after the falling clock edge. It gives events as one-cycle pulses with moderate probability and toggles the link and the enables rarely, so that long handshakes complete, while starts and link edges still arrive at random moments relative to timer expiries. A cycle-counting reference model in the bench predicts every output in every cycle, and directed phases pin down the retry limit, the success timing and the ignored-event cases.

// File: rtl/mmv_pkg.sv
// Package: shared status encoding for the verify handshake.
// Assumes: the codes are observed by software-facing logic outside this block.
package mmv_pkg;
    typedef enum logic [2:0] {
        ST_DISABLED  = 3'd0,
        ST_INITIAL   = 3'd1,
        ST_VERIFYING = 3'd2,
        ST_SUCCEEDED = 3'd3,
        ST_FAILED    = 3'd4
    } mmv_status_e;
endpackage

// File: rtl/mmv_interval_timer.sv
// Module: interval timer for the verify handshake.
// Counts clock cycles through a prescaler of CYC_PER_MS cycles per millisecond.
// arm_now makes it expire in the next cycle. rearm reloads it with max(interval,1) ms.
// stop halts it. expire stays high while the count is zero, until the owner
// issues arm_now, rearm or stop.
// Assumes: the owner reacts to every expiry in the same cycle.
module mmv_interval_timer #(
    parameter int CYC_PER_MS = 1000,
    parameter int MS_W       = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            arm_now,
    input  logic            rearm,
    input  logic            stop,
    input  logic [MS_W-1:0] interval_ms,
    output logic            expire
);
    localparam int PRE_W = (CYC_PER_MS > 1) ? $clog2(CYC_PER_MS) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CYC_PER_MS - 1);

    logic            running;
    logic [MS_W-1:0] ms_left;
    logic [PRE_W-1:0] pre_cnt;
    logic [MS_W-1:0] load_ms;

    // Purpose: a zero interval is treated as one millisecond.
    always_comb load_ms = (interval_ms == '0) ? MS_W'(1) : interval_ms;

    assign expire = running && (ms_left == '0);

    // Purpose: prescaled millisecond countdown with arm, rearm and stop control.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            ms_left <= '0;
            pre_cnt <= '0;
        end else if (arm_now) begin
            running <= 1'b1;
            ms_left <= '0;
            pre_cnt <= '0;
        end else if (rearm) begin
            running <= 1'b1;
            ms_left <= load_ms;
            pre_cnt <= '0;
        end else if (stop) begin
            running <= 1'b0;
        end else if (running && ms_left != '0) begin
            if (pre_cnt == PRE_LAST) begin
                pre_cnt <= '0;
                ms_left <= ms_left - 1'b1;
            end else begin
                pre_cnt <= pre_cnt + 1'b1;
            end
        end
    end

    // R3: a fresh reload never expires in the cycle that follows it
    p_rearm_no_expire_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rearm && !arm_now) |=> !expire);

    // R9: a stop with no reload leaves the timer silent in the next cycle
    p_stop_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && !rearm && !arm_now) |=> !expire);
endmodule

// File: rtl/mmv_handshake_core.sv
// Module: status and request logic of the verify handshake.
// Applies the timer expiry first, then events on the result. Disable, link-down,
// start and link-up override both. Issues one-cycle request pulses.
// Assumes: event inputs are single-cycle pulses synchronous to clk.
module mmv_handshake_core
    import mmv_pkg::*;
#(
    parameter int MAX_VERIFY = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_rx_en,
    input  logic        cfg_tx_en,
    input  logic        cfg_verify_en,
    input  logic        start,
    input  logic        link_ok,
    input  logic        ev_verify_sent,
    input  logic        ev_verify_rcvd,
    input  logic        ev_resp_rcvd,
    input  logic        expire,
    output logic        t_arm_now,
    output logic        t_rearm,
    output logic        t_stop,
    output mmv_status_e status,
    output logic        tx_preempt_en,
    output logic        rx_preempt_en,
    output logic        send_verify,
    output logic        send_resp
);
    localparam int RET_W = $clog2(MAX_VERIFY + 1);
    localparam logic [RET_W-1:0] RET_FULL = RET_W'(MAX_VERIFY);

    mmv_status_e      st_n;
    logic [RET_W-1:0] retries, ret_n;
    logic             tx_n, do_send, link_q;
    logic             rx_ok, up_edge, begin_hs;

    // Purpose: qualify events and detect link-up and handshake start.
    always_comb begin
        rx_ok    = cfg_rx_en && link_ok;
        up_edge  = link_ok && !link_q;
        begin_hs = cfg_verify_en && cfg_tx_en && rx_ok && (start || up_edge);
    end

    // Purpose: next status, retry budget, transmit enable and timer control.
    always_comb begin
        st_n      = status;
        ret_n     = retries;
        tx_n      = tx_preempt_en;
        do_send   = 1'b0;
        t_arm_now = 1'b0;
        t_rearm   = 1'b0;
        t_stop    = 1'b0;
        if (!link_ok) begin
            tx_n   = 1'b0;
            t_stop = 1'b1;
        end else if (!cfg_verify_en) begin
            st_n   = ST_DISABLED;
            tx_n   = cfg_tx_en;
            t_stop = 1'b1;
        end else if (begin_hs) begin
            st_n      = ST_INITIAL;
            ret_n     = RET_FULL;
            tx_n      = 1'b0;
            t_arm_now = 1'b1;
        end else if (up_edge) begin
            tx_n   = 1'b0;
            t_stop = 1'b1;
        end else begin
            if (expire) begin
                if (status == ST_INITIAL || status == ST_VERIFYING) begin
                    if (retries != '0) begin
                        do_send = 1'b1;
                        ret_n   = retries - 1'b1;
                        t_rearm = 1'b1;
                    end else begin
                        st_n   = ST_FAILED;
                        t_stop = 1'b1;
                    end
                end else begin
                    if (status == ST_SUCCEEDED) tx_n = 1'b1;
                    t_stop = 1'b1;
                end
            end
            if (rx_ok && ev_verify_sent && st_n == ST_INITIAL) st_n = ST_VERIFYING;
            if (rx_ok && ev_resp_rcvd && st_n == ST_VERIFYING) begin
                st_n    = ST_SUCCEEDED;
                t_rearm = 1'b1;
            end
        end
    end

    // Purpose: register state and request pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status        <= ST_DISABLED;
            retries       <= '0;
            tx_preempt_en <= 1'b0;
            rx_preempt_en <= 1'b0;
            send_verify   <= 1'b0;
            send_resp     <= 1'b0;
            link_q        <= 1'b0;
        end else begin
            status        <= st_n;
            retries       <= ret_n;
            tx_preempt_en <= tx_n;
            rx_preempt_en <= rx_ok;
            send_verify   <= do_send;
            send_resp     <= ev_verify_rcvd && rx_ok;
            link_q        <= link_ok;
        end
    end

    // R2: only the five defined codes appear
    p_status_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        status inside {ST_DISABLED, ST_INITIAL, ST_VERIFYING, ST_SUCCEEDED, ST_FAILED});

    // R4: a verify request always consumes budget that existed
    p_verify_budget_r4: assert property (@(posedge clk) disable iff (!rst_n)
        send_verify |-> ($past(retries) != '0 && $past(expire)));

    // R4: failure is entered only on an expiry with an empty budget
    p_fail_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status == ST_FAILED) |-> ($past(expire) && $past(retries) == '0));

    // R7: with verification on, transmit preemption rises only out of success
    p_tx_from_success_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(tx_preempt_en) && $past(cfg_verify_en)) |-> $past(status) == ST_SUCCEEDED);

    // R8: a response request always answers a qualified partner verify
    p_resp_answers_r8: assert property (@(posedge clk) disable iff (!rst_n)
        send_resp |-> ($past(ev_verify_rcvd) && $past(cfg_rx_en) && $past(link_ok)));

    // R9: link down removes both preemption enables
    p_link_down_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !link_ok |=> (!tx_preempt_en && !rx_preempt_en));

    // R6: success is entered only from verifying on a response
    p_success_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status == ST_SUCCEEDED) |-> ($past(ev_resp_rcvd) && $past(status) != ST_FAILED));
endmodule

// File: rtl/mm_verify_fsm.sv
// Module: top of the frame-preemption verify handshake controller.
// Connects the prescaled interval timer to the status and request core.
// Assumes: all inputs are synchronous to clk, and events are one-cycle pulses.
module mm_verify_fsm #(
    parameter int CYC_PER_MS = 1000,
    parameter int MS_W       = 8,
    parameter int MAX_VERIFY = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_rx_en,
    input  logic            cfg_tx_en,
    input  logic            cfg_verify_en,
    input  logic [MS_W-1:0] cfg_interval_ms,
    input  logic            start,
    input  logic            link_ok,
    input  logic            ev_verify_sent,
    input  logic            ev_verify_rcvd,
    input  logic            ev_resp_rcvd,
    output logic [2:0]      status,
    output logic            tx_preempt_en,
    output logic            rx_preempt_en,
    output logic            send_verify,
    output logic            send_resp
);
    import mmv_pkg::*;

    logic        expire, t_arm_now, t_rearm, t_stop;
    mmv_status_e st;

    assign status = st;

    mmv_interval_timer #(
        .CYC_PER_MS (CYC_PER_MS),
        .MS_W       (MS_W)
    ) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .arm_now     (t_arm_now),
        .rearm       (t_rearm),
        .stop        (t_stop),
        .interval_ms (cfg_interval_ms),
        .expire      (expire)
    );

    mmv_handshake_core #(
        .MAX_VERIFY (MAX_VERIFY)
    ) u_core (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_rx_en      (cfg_rx_en),
        .cfg_tx_en      (cfg_tx_en),
        .cfg_verify_en  (cfg_verify_en),
        .start          (start),
        .link_ok        (link_ok),
        .ev_verify_sent (ev_verify_sent),
        .ev_verify_rcvd (ev_verify_rcvd),
        .ev_resp_rcvd   (ev_resp_rcvd),
        .expire         (expire),
        .t_arm_now      (t_arm_now),
        .t_rearm        (t_rearm),
        .t_stop         (t_stop),
        .status         (st),
        .tx_preempt_en  (tx_preempt_en),
        .rx_preempt_en  (rx_preempt_en),
        .send_verify    (send_verify),
        .send_resp      (send_resp)
    );

    // R10: with verification off, no verify request is ever issued
    p_no_verify_when_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_verify_en && $past(!cfg_verify_en)) |-> !send_verify);
endmodule

// File: tb/mm_verify_fsm_bench.sv
// Bench: cycle-counting reference model plus directed phases and random stimulus.
module mm_verify_fsm_bench;
    localparam int CLK_PERIOD = 10;
    localparam int CYC        = 3;
    localparam int MSW        = 4;
    localparam int MAXV       = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_rx_en = 1'b0, cfg_tx_en = 1'b0, cfg_verify_en = 1'b0;
    logic [MSW-1:0] cfg_interval_ms = 4'd4;
    logic start = 1'b0, link_ok = 1'b0;
    logic ev_verify_sent = 1'b0, ev_verify_rcvd = 1'b0, ev_resp_rcvd = 1'b0;
    logic [2:0] status;
    logic tx_preempt_en, rx_preempt_en, send_verify, send_resp;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    string phase_tag = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    mm_verify_fsm #(.CYC_PER_MS(CYC), .MS_W(MSW), .MAX_VERIFY(MAXV)) u_mm_verify_fsm (
        .clk(clk), .rst_n(rst_n), .cfg_rx_en(cfg_rx_en), .cfg_tx_en(cfg_tx_en),
        .cfg_verify_en(cfg_verify_en), .cfg_interval_ms(cfg_interval_ms),
        .start(start), .link_ok(link_ok), .ev_verify_sent(ev_verify_sent),
        .ev_verify_rcvd(ev_verify_rcvd), .ev_resp_rcvd(ev_resp_rcvd),
        .status(status), .tx_preempt_en(tx_preempt_en), .rx_preempt_en(rx_preempt_en),
        .send_verify(send_verify), .send_resp(send_resp));

    // Reference model: status codes 0..4, timer kept as a count of remaining cycles.
    int m_status, m_ret, m_cnt;
    logic m_tx, m_rx, m_sv, m_sr, m_lq, m_run;

    function automatic int reload_cycles(input logic [MSW-1:0] ms);
        return ((ms == 0) ? 1 : int'(ms)) * CYC;
    endfunction

    always @(posedge clk) begin
        logic rxok, up, expn, sv;
        int act; // 0 none, 1 immediate, 2 reload, 3 stop
        if (!rst_n) begin
            m_status = 0; m_ret = 0; m_cnt = 0;
            m_tx = 0; m_rx = 0; m_sv = 0; m_sr = 0; m_lq = 0; m_run = 0;
        end else begin
            rxok = cfg_rx_en && link_ok;
            up   = link_ok && !m_lq;
            expn = m_run && (m_cnt == 0);
            sv = 0; act = 0;
            if (!link_ok) begin
                m_tx = 0; act = 3;
            end else if (!cfg_verify_en) begin
                m_status = 0; m_tx = cfg_tx_en; act = 3;
            end else if (cfg_tx_en && rxok && (start || up)) begin
                m_status = 1; m_ret = MAXV; m_tx = 0; act = 1;
            end else if (up) begin
                m_tx = 0; act = 3;
            end else begin
                if (expn) begin
                    if (m_status == 1 || m_status == 2) begin
                        if (m_ret > 0) begin sv = 1; m_ret--; act = 2; end
                        else begin m_status = 4; act = 3; end
                    end else begin
                        if (m_status == 3) m_tx = 1;
                        act = 3;
                    end
                end
                if (rxok && ev_verify_sent && m_status == 1) m_status = 2;
                if (rxok && ev_resp_rcvd && m_status == 2) begin m_status = 3; act = 2; end
            end
            m_sr = ev_verify_rcvd && rxok;
            m_sv = sv;
            m_rx = rxok;
            m_lq = link_ok;
            case (act)
                1: begin m_run = 1; m_cnt = 0; end
                2: begin m_run = 1; m_cnt = reload_cycles(cfg_interval_ms); end
                3: m_run = 0;
                default: if (m_run && m_cnt > 0) m_cnt--;
            endcase
        end
    end

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic compare_model();
        check(phase_tag, "status vs model", int'(status), m_status);
        check(phase_tag, "tx_preempt_en vs model", int'(tx_preempt_en), int'(m_tx));
        check(phase_tag, "rx_preempt_en vs model", int'(rx_preempt_en), int'(m_rx));
        check(phase_tag, "send_verify vs model", int'(send_verify), int'(m_sv));
        check(phase_tag, "send_resp vs model", int'(send_resp), int'(m_sr));
    endtask

    // One clock: inputs were set after a falling edge; compare at the next falling edge.
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        start = 0; ev_verify_sent = 0; ev_verify_rcvd = 0; ev_resp_rcvd = 0;
        if (rst_n) compare_model();
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            fails++;
            $display("FAIL R13 watchdog: actual %0d expected %0d", cyc, 0);
            summary();
            $finish;
        end
    end

    initial begin
        int npulse, guard;
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "status at reset", int'(status), 0);
        check("R1", "tx at reset", int'(tx_preempt_en), 0);
        check("R1", "rx at reset", int'(rx_preempt_en), 0);
        check("R1", "send_verify at reset", int'(send_verify), 0);
        rst_n = 1;
        tick();

        // R9 + R4: link-up with everything enabled starts; no partner -> fail after 3 requests
        phase_tag = "R4";
        cfg_rx_en = 1; cfg_tx_en = 1; cfg_verify_en = 1; cfg_interval_ms = 4'd4;
        link_ok = 1;
        tick();
        check("R9", "link-up starts at INITIAL", int'(status), 1);
        npulse = 0; guard = 0;
        while (status != 3'd4 && guard < 200) begin
            tick();
            if (send_verify) npulse++;
            guard++;
        end
        check("R4", "verify pulses before FAILED", npulse, MAXV);
        check("R4", "status FAILED", int'(status), 4);
        repeat (30) tick();
        check("R4", "no request after FAILED", int'(send_verify), 0);

        // R12 + R6 + R5: events do not leave FAILED
        phase_tag = "R12";
        ev_resp_rcvd = 1; ev_verify_sent = 1; tick();
        check("R12", "FAILED held under events", int'(status), 4);

        // R2 + R3: start, first request in second cycle, next after interval*CYC+1
        phase_tag = "R3";
        start = 1; tick();
        check("R2", "start gives INITIAL", int'(status), 1);
        check("R3", "no request yet", int'(send_verify), 0);
        tick();
        check("R3", "first request second cycle", int'(send_verify), 1);
        ev_resp_rcvd = 1; tick();
        check("R6", "response ignored in INITIAL", int'(status), 1);
        ev_verify_sent = 1; tick();
        check("R5", "verify-sent gives VERIFYING", int'(status), 2);
        ev_verify_sent = 1; tick();
        check("R5", "verify-sent in VERIFYING no change", int'(status), 2);
        npulse = 0;
        repeat (4*CYC + 1 - 4) begin tick(); if (send_verify) npulse++; end
        check("R3", "second request not early", npulse, 0);
        tick();
        check("R3", "second request on time", int'(send_verify), 1);

        // R6 + R7: success, transmit enable one interval plus one cycle later
        phase_tag = "R7";
        ev_resp_rcvd = 1; tick();
        check("R6", "response gives SUCCEEDED", int'(status), 3);
        repeat (4*CYC - 1) tick();
        check("R7", "tx still low before expiry", int'(tx_preempt_en), 0);
        tick();
        check("R7", "tx low in expiry cycle", int'(tx_preempt_en), 0);
        tick();
        check("R7", "tx enabled after expiry", int'(tx_preempt_en), 1);
        ev_verify_sent = 1; ev_resp_rcvd = 1; tick();
        check("R12", "SUCCEEDED held under events", int'(status), 3);

        // R8: partner verify answered in any state
        phase_tag = "R8";
        ev_verify_rcvd = 1; tick();
        check("R8", "response request next cycle", int'(send_resp), 1);
        tick();
        check("R8", "response request one cycle", int'(send_resp), 0);

        // R11: receive side off -> events ignored
        phase_tag = "R11";
        cfg_rx_en = 0; start = 1; tick();
        ev_verify_rcvd = 1; tick();
        check("R11", "no response request with rx off", int'(send_resp), 0);
        check("R11", "rx_preempt_en low", int'(rx_preempt_en), 0);
        check("R11", "start ignored without rx", int'(status), 3);
        cfg_rx_en = 1; tick();

        // R9: link down clears both enables; status held
        phase_tag = "R9";
        link_ok = 0; tick();
        check("R9", "tx off on link down", int'(tx_preempt_en), 0);
        check("R9", "rx off on link down", int'(rx_preempt_en), 0);
        check("R9", "status held on link down", int'(status), 3);
        link_ok = 1; tick();
        check("R9", "link-up restarts", int'(status), 1);

        // R10: verification disabled
        phase_tag = "R10";
        cfg_verify_en = 0; tick();
        check("R10", "status DISABLED", int'(status), 0);
        check("R10", "tx follows config", int'(tx_preempt_en), 1);
        cfg_tx_en = 0; tick();
        check("R10", "tx follows config low", int'(tx_preempt_en), 0);
        repeat (20) tick();
        check("R10", "no request when disabled", int'(send_verify), 0);

        // R13: random mix compared against the model every cycle
        phase_tag = "R13";
        cfg_verify_en = 1; cfg_tx_en = 1; start = 1; tick();
        for (int i = 0; i < 6000; i++) begin
            if ($urandom_range(0, 5) == 0) ev_verify_sent = 1;
            if ($urandom_range(0, 5) == 0) ev_verify_rcvd = 1;
            if ($urandom_range(0, 7) == 0) ev_resp_rcvd = 1;
            if ($urandom_range(0, 39) == 0) start = 1;
            if ($urandom_range(0, 149) == 0) link_ok = ~link_ok;
            if ($urandom_range(0, 299) == 0) cfg_rx_en = ~cfg_rx_en;
            if ($urandom_range(0, 299) == 0) cfg_tx_en = ~cfg_tx_en;
            if ($urandom_range(0, 299) == 0) cfg_verify_en = ~cfg_verify_en;
            if ($urandom_range(0, 199) == 0) cfg_interval_ms = MSW'($urandom_range(0, 5));
            tick();
        end

        summary();
        $finish;
    end
endmodule